// File: doc/BRIEF.md
# Battery-Backed Byte Store with Sticky Lockable Windows

This block is a small byte-addressable RAM that stands in for the battery-backed storage of a real-time clock. It has one register-style access port. A write enable commits a byte. A read enable loads the addressed byte into a registered output one cycle later.

Two fixed 8-byte windows inside the address space can each be sealed by a configuration bit. Once a window is sealed, two things happen. Writes that land in it are dropped. Reads from it return a constant filler byte and never the stored value.

Software can only set the seal bits. They stay set through a soft reset. Only the hard-reset input releases them. The stored bytes survive both resets, as battery-backed storage would.

Top module: `bbram_locked`

## Requirements
- R1: While either reset is high, and after either reset is released, the read-data output is 8'h00 until the first read.
- R2: When rd_en is high at a clock edge, rdata shows the byte stored at addr after that edge. While rd_en is low, rdata keeps its previous value.
- R3: A cfg_wr pulse with cfg_data bit 0 set seals window 0, which spans addresses WIN_BASES[5:0] to +7 (default 8'h10 to 8'h17). A pulse with bit 1 set seals window 1, which spans WIN_BASES[11:6] to +7 (default 8'h28 to 8'h2F).
- R4: A write to any address in a sealed window leaves the stored byte unchanged. The old value is still there once the seal is released.
- R5: A read from any address in a sealed window returns 8'hFF.
- R6: A configuration write with a 0 in a seal bit position does not clear that seal bit.
- R7: soft_rst clears rdata and ignores accesses and configuration writes while it is held. Both seal bits and every stored byte are unchanged afterwards.
- R8: hard_rst clears both seal bits and leaves the stored bytes intact.
- R9: The two windows seal independently. Addresses just outside a sealed window, and the unsealed window, read and write normally.
- R10: A read and a write to the same address in the same cycle return the byte stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| hard_rst | input | 1 | Synchronous active-high reset; also releases the seals |
| soft_rst | input | 1 | Synchronous active-high reset; seals and contents are kept |
| addr | input | 6 | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; data appears after the edge |
| rdata | output | 8 | Registered read data |
| cfg_wr | input | 1 | Configuration write strobe for the seal bits |
| cfg_data | input | 2 | Seal bits to set: bit 0 for window 0, bit 1 for window 1 |

## Verification
A seal bit that is lost or never set shows up at the first read inside its window, one cycle after the read strobe. That read returns the stored byte where 8'hFF is expected. A write that leaks past a seal shows up later: only after a hard reset releases the seal does a read return the altered byte instead of the original. The bench therefore pairs every sealed write with a read-back after the hard reset. It also probes the addresses on either side of each window, which exposes an off-by-one in the window decode on the first read.

// File: rtl/bbram_pkg.sv
package bbram_pkg;

    localparam int unsigned ADDR_W   = 6;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned WIN_N    = 2;
    localparam int unsigned WIN_SPAN = 8;
    localparam int unsigned DEPTH    = 1 << ADDR_W;
    localparam int unsigned SPAN_W   = $clog2(WIN_SPAN);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [WIN_N-1:0]  seal_t;

    localparam data_t FILL_BYTE = 8'hFF;

    typedef struct packed {
        logic  wr;
        logic  rd;
        addr_t addr;
        data_t wdata;
    } access_t;

    typedef enum logic [1:0] {
        RSRC_HOLD,
        RSRC_MEM,
        RSRC_FILL,
        RSRC_CLEAR
    } rsrc_e;

    function automatic logic in_window(addr_t a, addr_t base);
        return (a >> SPAN_W) == (base >> SPAN_W);
    endfunction

endpackage

// File: rtl/bbram_seal_regs.sv
module bbram_seal_regs
    import bbram_pkg::*;
(
    input  logic  clk,
    input  logic  hard_rst,
    input  logic  set_en,
    input  seal_t set_bits,
    output seal_t seal_q
);

    always_ff @(posedge clk) begin
        if (hard_rst)
            seal_q <= '0;
        else if (set_en)
            seal_q <= seal_q | set_bits;
    end

endmodule

// File: rtl/bbram_guard.sv
module bbram_guard
    import bbram_pkg::*;
#(
    parameter logic [WIN_N*ADDR_W-1:0] WIN_BASES = {6'h28, 6'h10}
) (
    input  addr_t addr,
    input  seal_t seal,
    output logic  blocked
);

    seal_t hit;

    for (genvar w = 0; w < WIN_N; w++) begin : g_win
        localparam addr_t BASE = WIN_BASES[w*ADDR_W +: ADDR_W];
        assign hit[w] = seal[w] && in_window(addr, BASE);
    end

    assign blocked = |hit;

endmodule

// File: rtl/bbram_store.sv
module bbram_store
    import bbram_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  addr_t addr,
    input  data_t wdata,
    output data_t rd_byte
);

    data_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    assign rd_byte = mem[addr];

endmodule

// File: rtl/bbram_locked.sv
module bbram_locked
    import bbram_pkg::*;
#(
    parameter logic [WIN_N*ADDR_W-1:0] WIN_BASES = {6'h28, 6'h10}
) (
    input  logic        clk,
    input  logic        hard_rst,
    input  logic        soft_rst,
    input  logic [5:0]  addr,
    input  logic [7:0]  wdata,
    input  logic        wr_en,
    input  logic        rd_en,
    output logic [7:0]  rdata,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_data
);

    access_t req;
    seal_t   seal_q;
    logic    blocked;
    logic    any_rst;
    data_t   mem_byte;
    rsrc_e   rsrc;
    data_t   rdata_q;

    assign any_rst   = hard_rst | soft_rst;
    assign req.wr    = wr_en & ~any_rst;
    assign req.rd    = rd_en & ~any_rst;
    assign req.addr  = addr;
    assign req.wdata = wdata;

    bbram_seal_regs u_seal (
        .clk      (clk),
        .hard_rst (hard_rst),
        .set_en   (cfg_wr & ~soft_rst),
        .set_bits (cfg_data),
        .seal_q   (seal_q)
    );

    bbram_guard #(.WIN_BASES(WIN_BASES)) u_guard (
        .addr    (req.addr),
        .seal    (seal_q),
        .blocked (blocked)
    );

    bbram_store u_store (
        .clk     (clk),
        .we      (req.wr & ~blocked),
        .addr    (req.addr),
        .wdata   (req.wdata),
        .rd_byte (mem_byte)
    );

    always_comb begin
        if (any_rst)
            rsrc = RSRC_CLEAR;
        else if (req.rd && blocked)
            rsrc = RSRC_FILL;
        else if (req.rd)
            rsrc = RSRC_MEM;
        else
            rsrc = RSRC_HOLD;
    end

    always_ff @(posedge clk) begin
        case (rsrc)
            RSRC_CLEAR: rdata_q <= '0;
            RSRC_FILL:  rdata_q <= FILL_BYTE;
            RSRC_MEM:   rdata_q <= mem_byte;
            default:    rdata_q <= rdata_q;
        endcase
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/bbram_locked_chk.sv
module bbram_locked_chk
    import bbram_pkg::*;
#(
    parameter logic [WIN_N*ADDR_W-1:0] WIN_BASES = {6'h28, 6'h10}
) (
    input logic        clk,
    input logic        hard_rst,
    input logic        soft_rst,
    input logic [5:0]  addr,
    input logic        rd_en,
    input logic [7:0]  rdata,
    input logic [1:0]  seal_q
);

    logic sealed_hit;
    assign sealed_hit =
        (seal_q[0] && in_window(addr, WIN_BASES[0 +: ADDR_W])) ||
        (seal_q[1] && in_window(addr, WIN_BASES[ADDR_W +: ADDR_W]));

    // R2
    read_hold_chk: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
        !rd_en |=> $stable(rdata));

    // R5
    sealed_fill_chk: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
        (rd_en && sealed_hit) |=> (rdata == 8'hFF));

    // R6
    seal0_sticky_chk: assert property (@(posedge clk) disable iff (hard_rst)
        seal_q[0] |=> seal_q[0]);

    // R6
    seal1_sticky_chk: assert property (@(posedge clk) disable iff (hard_rst)
        seal_q[1] |=> seal_q[1]);

    // R7
    soft_keep_chk: assert property (@(posedge clk) disable iff (hard_rst)
        soft_rst |=> ((rdata == 8'h00) && $stable(seal_q)));

    // R8
    hard_clear_chk: assert property (@(posedge clk) disable iff (soft_rst)
        hard_rst |=> (seal_q == 2'b00));

endmodule

bind bbram_locked bbram_locked_chk #(.WIN_BASES(WIN_BASES)) u_chk (
    .clk      (clk),
    .hard_rst (hard_rst),
    .soft_rst (soft_rst),
    .addr     (addr),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .seal_q   (seal_q)
);

// File: tb/tb_bbram_locked.sv
`timescale 1ns/1ps
module tb_bbram_locked;

    logic       clk = 1'b0;
    logic       hard_rst = 1'b0;
    logic       soft_rst = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_data = '0;

    int checks = 0;
    int errors = 0;

    logic [7:0] model [64];
    logic [1:0] lk = 2'b00;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       pend = 1'b0;

    always #5 clk = ~clk;

    bbram_locked dut (
        .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst),
        .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
        .rdata(rdata), .cfg_wr(cfg_wr), .cfg_data(cfg_data)
    );

    function automatic logic sealed(logic [5:0] a);
        return (lk[0] && a >= 6'h10 && a <= 6'h17) ||
               (lk[1] && a >= 6'h28 && a <= 6'h2F);
    endfunction

    function automatic logic [7:0] pattern(int a);
        return 8'((a * 37) + 91);
    endfunction

    task automatic compare(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: pops expected reads one cycle after the strobe
    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard underflow actual=%02h expected=none", rdata);
            end else begin
                compare(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
        pend = rd_en;
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
        if (!sealed(a)) model[a] = d;
    endtask

    task automatic rd(logic [5:0] a, string tag);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(sealed(a) ? 8'hFF : model[a]);
        tag_q.push_back(tag);
        tick();
        rd_en = 1'b0;
    endtask

    task automatic cfg(logic [1:0] bits);
        cfg_wr = 1'b1; cfg_data = bits;
        tick();
        cfg_wr = 1'b0; cfg_data = '0;
        lk = lk | bits;
    endtask

    task automatic do_hard();
        hard_rst = 1'b1;
        tick(); tick();
        hard_rst = 1'b0;
        lk = 2'b00;
    endtask

    task automatic finish_up();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        tick();
        do_hard();
        // R1: output cleared after reset
        compare("R1 reset rdata", rdata, 8'h00);

        for (int a = 0; a < 64; a++) wr(6'(a), pattern(a));
        for (int a = 0; a < 64; a++) rd(6'(a), "R2 plain readback");
        tick();
        // R2: output holds with no read strobe
        compare("R2 hold", rdata, model[63]);
        tick(); tick();
        compare("R2 hold later", rdata, model[63]);

        // R3: seal window 0 only
        cfg(2'b01);
        for (int a = 16; a < 24; a++) rd(6'(a), "R3 R5 window0 sealed read");
        rd(6'h0F, "R9 below window0");
        rd(6'h18, "R9 above window0");
        rd(6'h28, "R9 window1 unsealed");
        rd(6'h2F, "R9 window1 unsealed top");
        wr(6'h12, 8'hAA);
        wr(6'h10, 8'h11);
        wr(6'h18, 8'h55);
        wr(6'h0F, 8'h66);
        rd(6'h12, "R4 R5 sealed after write");
        rd(6'h18, "R9 write next to window");
        rd(6'h0F, "R9 write before window");

        // R6: zero write does not clear
        cfg(2'b00);
        rd(6'h10, "R6 still sealed");
        wr(6'h2A, 8'h3C);
        rd(6'h2A, "R9 window1 writable");

        // R7: soft reset keeps seals and contents
        tick();
        soft_rst = 1'b1;
        addr = 6'h2A; wdata = 8'h99; wr_en = 1'b1; cfg_wr = 1'b1; cfg_data = 2'b10;
        tick();
        compare("R7 rdata during soft reset", rdata, 8'h00);
        wr_en = 1'b0; cfg_wr = 1'b0; cfg_data = '0;
        soft_rst = 1'b0;
        tick();
        compare("R7 rdata after soft reset", rdata, 8'h00);
        rd(6'h10, "R7 seal0 kept");
        rd(6'h2A, "R7 contents kept, seal1 not set");
        rd(6'h18, "R7 contents kept");

        // R3: seal window 1 as well
        cfg(2'b10);
        rd(6'h2A, "R3 R5 window1 sealed");
        rd(6'h27, "R9 below window1");
        rd(6'h30, "R9 above window1");
        wr(6'h2C, 8'h00);

        // R10: same-cycle read and write
        addr = 6'h05; wdata = 8'hC3; wr_en = 1'b1; rd_en = 1'b1;
        exp_q.push_back(model[5]); tag_q.push_back("R10 read before write");
        tick();
        wr_en = 1'b0; rd_en = 1'b0;
        model[5] = 8'hC3;
        rd(6'h05, "R10 new value");

        // R8: hard reset releases seals, contents kept
        do_hard();
        compare("R1 R8 rdata after hard reset", rdata, 8'h00);
        rd(6'h12, "R4 R8 blocked write left old byte");
        rd(6'h10, "R4 R8 blocked write left old byte");
        rd(6'h2C, "R4 R8 window1 old byte");
        rd(6'h2A, "R8 window1 readable");
        wr(6'h14, 8'h77);
        rd(6'h14, "R8 window0 writable again");

        tick(); tick();
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        finish_up();
    end

endmodule